// File: doc/BRIEF.md
# Ternary Content Addressable Memory

This block is a small ternary lookup array: 32 stored 32-bit patterns, each bit of which compares as 0, 1 or don't-care. A caller loads a pattern through a 16-bit request port over two cycles. It can then add a don't-care mask for that entry in a separate three-cycle sequence. A 32-bit search key is compared against every stored entry in parallel. The result comes back on the next cycle as a match-found flag, a multiple-match flag and a 5-bit entry index. The index is only usable when exactly one entry matched. When several entries match, the caller can ask for the raw 32-bit hit vector, which is returned as two 16-bit beats so that it can resolve the case externally. Per-entry data is not held here. A separate RAM addressed by the returned index provides it.

A 3-bit operation code selects the request. The codes are search = 0, search with vector readout = 1, pattern write = 2, mask write = 3 and entry clear = 4. A request counts only when `busy` is low. Multi-cycle operations raise `busy` for their extra cycles, and any request presented while `busy` is high is dropped.

The controller is a state machine with six states:
- ST_IDLE accepts requests.
- ST_PAT_HI takes the high pattern half and returns to ST_IDLE.
- ST_MSK_HI takes the high mask half and goes to ST_MSK_COMMIT.
- ST_MSK_COMMIT installs the mask and returns to ST_IDLE.
- ST_VEC_LO presents the low vector beat and goes to ST_VEC_HI.
- ST_VEC_HI presents the high beat and returns to ST_IDLE.

From ST_IDLE, an accepted request selects the next state as follows:
- code 1 moves to ST_VEC_LO.
- code 2 moves to ST_PAT_HI.
- code 3 moves to ST_MSK_HI.
- codes 0 and 4 stay in ST_IDLE.

Top module: `tcam_core`

## Requirements
- R1: After reset every entry is invalid, `busy`, `hit_valid` and `vec_valid` are low, and a search for any key reports no match.
- R2: A pattern write (code 2) takes the low 16 bits from `req_data` and the entry number from `req_idx` in the accept cycle, then the high 16 bits from `req_data` in the following cycle. The entry becomes valid and searchable after that second cycle, and it compares exactly on all 32 bits.
- R3: A mask write (code 3) takes the low half in the accept cycle, the high half in the next cycle, and installs the mask on the third cycle. A mask bit of 1 makes that key bit a don't-care for that entry only.
- R4: A pattern write to an entry drops any mask previously installed on it, so the entry compares exactly again until a new mask is written.
- R5: A clear (code 4) invalidates one entry in a single cycle and leaves `busy` low. An invalid entry never matches.
- R6: For a search (code 0 or 1) accepted at a clock edge, `hit_valid` is high for the cycle after that edge. When exactly one entry matches, `hit_found` = 1, `hit_multi` = 0 and `hit_idx` holds that entry's number.
- R7: When two or more entries match, `hit_found` = 1 and `hit_multi` = 1.
- R8: When no entry matches, `hit_found` = 0, `hit_multi` = 0 and `hit_idx` = 0.
- R9: A code 1 search also returns the hit vector. One cycle after the result, `vec_valid` = 1 with `vec_beat` = 0 and hit flags for entries 15..0 on `vec_data`, where bit n stands for entry n. On the next cycle `vec_valid` = 1 with `vec_beat` = 1 and hit flags for entries 31..16.
- R10: `busy` is high for one cycle after a pattern accept and for two cycles after a mask accept or a code 1 search. A request presented while `busy` is high produces no result and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (0 search, 1 search with vector, 2 pattern, 3 mask, 4 clear) |
| req_idx | input | 5 | Entry number for write and clear |
| req_data | input | 16 | Pattern or mask half: low half in the accept cycle, high half on the next cycle |
| search_key | input | 32 | Key compared in the search accept cycle |
| busy | output | 1 | A multi-cycle operation is in progress; requests are dropped |
| hit_valid | output | 1 | Search result present this cycle |
| hit_found | output | 1 | At least one entry matched |
| hit_multi | output | 1 | Two or more entries matched |
| hit_idx | output | 5 | Matching entry number; zero on no match |
| vec_valid | output | 1 | Hit-vector beat present |
| vec_beat | output | 1 | 0 for entries 15..0, 1 for entries 31..16 |
| vec_data | output | 16 | Hit-vector beat |

## Verification
The assertions assume that callers raise `req_valid` only as a request. They also assume that the high half of a pattern or mask is placed on `req_data` in the cycle right after the accept. In that cycle `req_valid` is ignored. The stimulus presents each high half in exactly that cycle. It deliberately holds `req_valid` high in some busy cycles to show that those requests are dropped. It uses only the five defined operation codes. A behavioural model in the bench tracks every entry and predicts `busy`, the search result and both vector beats, and these are compared on every cycle.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic [2:0] {
        OP_SEARCH     = 3'd0,
        OP_SEARCH_VEC = 3'd1,
        OP_PATTERN    = 3'd2,
        OP_MASK       = 3'd3,
        OP_CLEAR      = 3'd4
    } tcam_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAT_HI,
        ST_MSK_HI,
        ST_MSK_COMMIT,
        ST_VEC_LO,
        ST_VEC_HI
    } tcam_state_e;

endpackage

// File: rtl/tcam_entry.sv
// One stored ternary word: pattern, don't-care mask, mask enable, valid.
module tcam_entry #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pat_we,
    input  logic         msk_we,
    input  logic         clr_we,
    input  logic [W-1:0] wr_word,
    input  logic [W-1:0] key,
    output logic         hit
);
    logic [W-1:0] pat_q;
    logic [W-1:0] dc_q;
    logic         dc_on_q;
    logic         vld_q;
    logic [W-1:0] ignore;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q   <= '0;
            dc_q    <= '0;
            dc_on_q <= 1'b0;
            vld_q   <= 1'b0;
        end else if (clr_we) begin
            vld_q   <= 1'b0;
            dc_on_q <= 1'b0;
        end else if (pat_we) begin
            pat_q   <= wr_word;
            vld_q   <= 1'b1;
            dc_on_q <= 1'b0;    // a fresh pattern compares exactly
        end else if (msk_we) begin
            dc_q    <= wr_word;
            dc_on_q <= 1'b1;
        end
    end

    always_comb begin
        ignore = dc_on_q ? dc_q : '0;
        hit    = vld_q && (((key ^ pat_q) & ~ignore) == '0);
    end

endmodule

// File: rtl/tcam_encoder.sv
// Hit-vector encoder: any/many flags and an index valid only for a lone hit.
module tcam_encoder #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic          multi,
    output logic [IW-1:0] idx
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                cnt = cnt + CW'(1);
                idx = idx | IW'(i);
            end
        end
        found = (cnt != '0);
        multi = (cnt > CW'(1));
    end

endmodule

// File: rtl/tcam_ctrl.sv
// Sequencer for writes, mask installs, searches and the two-beat readout.
module tcam_ctrl
    import tcam_pkg::*;
#(
    parameter int N  = 32,
    parameter int W  = 32,
    parameter int IW = $clog2(N),
    parameter int HW = W / 2,
    parameter int VH = N / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [IW-1:0] req_idx,
    input  logic [HW-1:0] req_data,
    input  logic [N-1:0]  match_vec,
    input  logic          enc_found,
    input  logic          enc_multi,
    input  logic [IW-1:0] enc_idx,
    output logic          busy,
    output logic          pat_we,
    output logic          msk_we,
    output logic          clr_we,
    output logic [IW-1:0] we_idx,
    output logic [W-1:0]  we_word,
    output logic          hit_valid,
    output logic          hit_found,
    output logic          hit_multi,
    output logic [IW-1:0] hit_idx,
    output logic          vec_valid,
    output logic          vec_beat,
    output logic [VH-1:0] vec_data
);
    tcam_state_e   state_q, state_d;
    tcam_op_e      op;
    logic          accept;
    logic          is_search;
    logic [HW-1:0] lo_buf_q;
    logic [IW-1:0] idx_buf_q;
    logic [W-1:0]  mask_buf_q;
    logic [N-1:0]  snap_q;

    assign op        = tcam_op_e'(req_op);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign is_search = (op == OP_SEARCH) || (op == OP_SEARCH_VEC);
    assign busy      = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (op)
                        OP_SEARCH_VEC: state_d = ST_VEC_LO;
                        OP_PATTERN:    state_d = ST_PAT_HI;
                        OP_MASK:       state_d = ST_MSK_HI;
                        default:       state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PAT_HI:     state_d = ST_IDLE;
            ST_MSK_HI:     state_d = ST_MSK_COMMIT;
            ST_MSK_COMMIT: state_d = ST_IDLE;
            ST_VEC_LO:     state_d = ST_VEC_HI;
            ST_VEC_HI:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // entry write strobes
    always_comb begin
        pat_we  = (state_q == ST_PAT_HI);
        msk_we  = (state_q == ST_MSK_COMMIT);
        clr_we  = accept && (op == OP_CLEAR);
        we_idx  = clr_we ? req_idx : idx_buf_q;
        we_word = msk_we ? mask_buf_q : {req_data, lo_buf_q};
    end

    // registered outputs and capture buffers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_valid  <= 1'b0;
            hit_found  <= 1'b0;
            hit_multi  <= 1'b0;
            hit_idx    <= '0;
            vec_valid  <= 1'b0;
            vec_beat   <= 1'b0;
            vec_data   <= '0;
            lo_buf_q   <= '0;
            idx_buf_q  <= '0;
            mask_buf_q <= '0;
            snap_q     <= '0;
        end else begin
            hit_valid <= 1'b0;
            vec_valid <= 1'b0;
            if (accept && is_search) begin
                hit_valid <= 1'b1;
                hit_found <= enc_found;
                hit_multi <= enc_multi;
                hit_idx   <= enc_idx;
            end
            if (accept && (op == OP_SEARCH_VEC)) snap_q <= match_vec;
            if (accept && ((op == OP_PATTERN) || (op == OP_MASK))) begin
                lo_buf_q  <= req_data;
                idx_buf_q <= req_idx;
            end
            unique case (state_q)
                ST_MSK_HI: mask_buf_q <= {req_data, lo_buf_q};
                ST_VEC_LO: begin
                    vec_valid <= 1'b1;
                    vec_beat  <= 1'b0;
                    vec_data  <= snap_q[VH-1:0];
                end
                ST_VEC_HI: begin
                    vec_valid <= 1'b1;
                    vec_beat  <= 1'b1;
                    vec_data  <= snap_q[N-1:VH];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tcam_core.sv
module tcam_core #(
    parameter int N = 32,
    parameter int W = 32,
    localparam int IW = $clog2(N),
    localparam int HW = W / 2,
    localparam int VH = N / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [IW-1:0] req_idx,
    input  logic [HW-1:0] req_data,
    input  logic [W-1:0]  search_key,
    output logic          busy,
    output logic          hit_valid,
    output logic          hit_found,
    output logic          hit_multi,
    output logic [IW-1:0] hit_idx,
    output logic          vec_valid,
    output logic          vec_beat,
    output logic [VH-1:0] vec_data
);
    logic          pat_we, msk_we, clr_we;
    logic [IW-1:0] we_idx;
    logic [W-1:0]  we_word;
    logic [N-1:0]  match_vec;
    logic          enc_found, enc_multi;
    logic [IW-1:0] enc_idx;

    tcam_ctrl #(.N(N), .W(W), .IW(IW), .HW(HW), .VH(VH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_idx   (req_idx),
        .req_data  (req_data),
        .match_vec (match_vec),
        .enc_found (enc_found),
        .enc_multi (enc_multi),
        .enc_idx   (enc_idx),
        .busy      (busy),
        .pat_we    (pat_we),
        .msk_we    (msk_we),
        .clr_we    (clr_we),
        .we_idx    (we_idx),
        .we_word   (we_word),
        .hit_valid (hit_valid),
        .hit_found (hit_found),
        .hit_multi (hit_multi),
        .hit_idx   (hit_idx),
        .vec_valid (vec_valid),
        .vec_beat  (vec_beat),
        .vec_data  (vec_data)
    );

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic sel;
        assign sel = (we_idx == IW'(g));
        tcam_entry #(.W(W)) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .pat_we  (pat_we && sel),
            .msk_we  (msk_we && sel),
            .clr_we  (clr_we && sel),
            .wr_word (we_word),
            .key     (search_key),
            .hit     (match_vec[g])
        );
    end

    tcam_encoder #(.N(N), .IW(IW)) u_enc (
        .vec   (match_vec),
        .found (enc_found),
        .multi (enc_multi),
        .idx   (enc_idx)
    );

endmodule

// File: rtl/tcam_sva.sv
module tcam_sva
    import tcam_pkg::*;
#(
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic          busy,
    input logic          hit_valid,
    input logic          hit_found,
    input logic          hit_multi,
    input logic [IW-1:0] hit_idx,
    input logic          vec_valid,
    input logic          vec_beat
);
    logic acc;
    assign acc = req_valid && !busy;

    AST_PATTERN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == OP_PATTERN |=> busy);                               // R2
    AST_MASK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == OP_MASK |=> busy ##1 busy);                         // R3
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == OP_CLEAR |=> !busy);                                // R5
    AST_SEARCH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (req_op == OP_SEARCH || req_op == OP_SEARCH_VEC) |=> hit_valid); // R6
    AST_MULTI_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && hit_multi |-> hit_found);                               // R7
    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && !hit_found |-> hit_idx == '0 && !hit_multi);            // R8
    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && !vec_beat |=> vec_valid && vec_beat);                   // R9
    AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !hit_valid);                                                // R10

endmodule

bind tcam_core tcam_sva #(.IW(IW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .busy      (busy),
    .hit_valid (hit_valid),
    .hit_found (hit_found),
    .hit_multi (hit_multi),
    .hit_idx   (hit_idx),
    .vec_valid (vec_valid),
    .vec_beat  (vec_beat)
);

// File: tb/tcam_core_bench.sv
`timescale 1ns/1ps
module tcam_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [4:0]  req_idx = '0;
    logic [15:0] req_data = '0;
    logic [31:0] search_key = '0;
    logic        busy, hit_valid, hit_found, hit_multi, vec_valid, vec_beat;
    logic [4:0]  hit_idx;
    logic [15:0] vec_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;

    always #2.5 clk = ~clk;

    tcam_core u_tcam_core (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_data(req_data), .search_key(search_key),
        .busy(busy), .hit_valid(hit_valid), .hit_found(hit_found),
        .hit_multi(hit_multi), .hit_idx(hit_idx), .vec_valid(vec_valid),
        .vec_beat(vec_beat), .vec_data(vec_data)
    );

    // behavioural reference
    logic [31:0] m_pat [32];
    logic [31:0] m_dc  [32];
    bit          m_dcon[32];
    bit          m_vld [32];
    int          phase = 0;   // 0 idle,1 pat hi,2 mask hi,3 mask install,4 beat lo,5 beat hi
    logic [15:0] m_lo;
    int          m_ent;
    logic [31:0] m_mask;
    logic [31:0] m_snap;
    bit          e_hv, e_found, e_multi, e_vv, e_beat;
    int          e_idx;
    logic [15:0] e_vdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hits(input logic [31:0] k);
        logic [31:0] v = '0;
        for (int e = 0; e < 32; e++) begin
            logic [31:0] d = m_dcon[e] ? m_dc[e] : 32'h0;
            if (m_vld[e] && ((k | d) == (m_pat[e] | d))) v[e] = 1'b1;
        end
        return v;
    endfunction

    task automatic model_step();
        logic [31:0] v;
        int n;
        e_hv = 0; e_vv = 0;
        case (phase)
            0: if (req_valid) begin
                case (int'(req_op))
                    0, 1: begin
                        v = hits(search_key);
                        n = 0; e_idx = 0;
                        for (int e = 0; e < 32; e++) if (v[e]) begin n++; e_idx = e; end
                        if (n != 1) e_idx = 0;
                        e_hv = 1; e_found = (n > 0); e_multi = (n > 1);
                        if (req_op == 3'd1) begin m_snap = v; phase = 4; end
                    end
                    2: begin m_lo = req_data; m_ent = int'(req_idx); phase = 1; end
                    3: begin m_lo = req_data; m_ent = int'(req_idx); phase = 2; end
                    4: begin m_vld[req_idx] = 0; m_dcon[req_idx] = 0; end
                    default: ;
                endcase
            end
            1: begin m_pat[m_ent] = {req_data, m_lo}; m_vld[m_ent] = 1; m_dcon[m_ent] = 0; phase = 0; end
            2: begin m_mask = {req_data, m_lo}; phase = 3; end
            3: begin m_dc[m_ent] = m_mask; m_dcon[m_ent] = 1; phase = 0; end
            4: begin e_vv = 1; e_beat = 0; e_vdata = m_snap[15:0]; phase = 5; end
            5: begin e_vv = 1; e_beat = 1; e_vdata = m_snap[31:16]; phase = 0; end
            default: phase = 0;
        endcase
    endtask

    task automatic compare_all();
        chk(busy == (phase != 0), "R10 busy", 32'(busy), 32'(phase != 0));
        chk(hit_valid == e_hv, "R6 hit_valid", 32'(hit_valid), 32'(e_hv));
        if (e_hv && hit_valid) begin
            chk(hit_found == e_found, "R6 hit_found", 32'(hit_found), 32'(e_found));
            chk(hit_multi == e_multi, "R7 hit_multi", 32'(hit_multi), 32'(e_multi));
            if (!e_multi)
                chk(hit_idx == 5'(e_idx), e_found ? "R6 hit_idx" : "R8 hit_idx", 32'(hit_idx), 32'(e_idx));
        end
        chk(vec_valid == e_vv, "R9 vec_valid", 32'(vec_valid), 32'(e_vv));
        if (e_vv && vec_valid) begin
            chk(vec_beat == e_beat, "R9 vec_beat", 32'(vec_beat), 32'(e_beat));
            chk(vec_data == e_vdata, "R9 vec_data", 32'(vec_data), 32'(e_vdata));
        end
    endtask

    task automatic cycle(input bit v, input int op, input int ix, input logic [15:0] d, input logic [31:0] k);
        req_valid = v; req_op = 3'(op); req_idx = 5'(ix); req_data = d; search_key = k;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(); cycle(0, 0, 0, 16'h0, 32'h0); endtask

    task automatic put_pattern(input int ix, input logic [31:0] p);
        cycle(1, 2, ix, p[15:0], 32'h0);
        cycle(0, 0, 0, p[31:16], 32'h0);
    endtask

    task automatic put_mask(input int ix, input logic [31:0] m);
        cycle(1, 3, ix, m[15:0], 32'h0);
        cycle(0, 0, 0, m[31:16], 32'h0);
        cycle(0, 0, 0, 16'h0, 32'h0);
    endtask

    // hand-computed expectations, independent of the model
    task automatic expect_search(input string tag, input logic [31:0] k, input bit f, input bit m, input int ix);
        cycle(1, 0, 0, 16'h0, k);
        chk(hit_valid == 1'b1, tag, 32'(hit_valid), 32'h1);
        chk(hit_found == f, tag, 32'(hit_found), 32'(f));
        chk(hit_multi == m, tag, 32'(hit_multi), 32'(m));
        if (!m) chk(hit_idx == 5'(ix), tag, 32'(hit_idx), 32'(ix));
    endtask

    task automatic expect_vector(input string tag, input logic [31:0] k, input logic [31:0] exp_vec);
        cycle(1, 1, 0, 16'h0, k);
        idle();
        chk(vec_valid && !vec_beat && vec_data == exp_vec[15:0], tag, 32'(vec_data), exp_vec[15:0]);
        idle();
        chk(vec_valid && vec_beat && vec_data == exp_vec[31:16], tag, 32'(vec_data), exp_vec[31:16]);
    endtask

    initial begin
        logic [31:0] lfsr = 32'h1;
        for (int e = 0; e < 32; e++) begin
            m_pat[e] = '0; m_dc[e] = '0; m_dcon[e] = 0; m_vld[e] = 0;
        end
        e_hv = 0; e_vv = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(!busy && !hit_valid && !vec_valid, "R1 reset outputs", {29'h0, busy, hit_valid, vec_valid}, 32'h0);
        expect_search("R1 empty array search", 32'h0000_0000, 0, 0, 0);
        // R2: exact pattern
        put_pattern(3, 32'hDEAD_BEEF);
        expect_search("R2 exact hit", 32'hDEAD_BEEF, 1, 0, 3);
        expect_search("R2 one bit off", 32'hDEAD_BEEE, 0, 0, 0);
        // R10: request during the high-half cycle is dropped
        cycle(1, 2, 5, 16'hAAAA, 32'h0);
        cycle(1, 0, 0, 16'h5555, 32'hDEAD_BEEF);
        chk(!hit_valid, "R10 search dropped while busy", 32'(hit_valid), 32'h0);
        expect_search("R2 entry after busy write", 32'h5555_AAAA, 1, 0, 5);
        // R3: masked low byte
        put_pattern(7, 32'h1234_5678);
        put_mask(7, 32'h0000_00FF);
        expect_search("R3 masked hit", 32'h1234_56AB, 1, 0, 7);
        expect_search("R3 unmasked bit differs", 32'h1334_56AB, 0, 0, 0);
        // R7 / R9: two hits and vector readout
        put_pattern(9, 32'h1234_5600);
        expect_search("R7 two entries", 32'h1234_5600, 1, 1, 0);
        expect_vector("R9 vector entries 7 and 9", 32'h1234_5600, 32'h0000_0280);
        // R4: rewrite drops mask
        put_pattern(7, 32'h1234_5678);
        expect_search("R4 mask dropped", 32'h1234_56AB, 0, 0, 0);
        expect_search("R4 exact after rewrite", 32'h1234_5678, 1, 0, 7);
        // R5: clear
        cycle(1, 4, 3, 16'h0, 32'h0);
        chk(!busy, "R5 clear single cycle", 32'(busy), 32'h0);
        expect_search("R5 cleared entry", 32'hDEAD_BEEF, 0, 0, 0);
        // R6 / R9: top entry
        put_pattern(31, 32'hFFFF_FFFF);
        expect_search("R6 top entry", 32'hFFFF_FFFF, 1, 0, 31);
        expect_vector("R9 high beat bit 15", 32'hFFFF_FFFF, 32'h8000_0000);
        // R3 / R7: full don't-care entry 0
        put_pattern(0, 32'h0);
        put_mask(0, 32'hFFFF_FFFF);
        expect_search("R3 all don't-care", 32'hCAFE_F00D, 1, 0, 0);
        expect_search("R7 wildcard plus top", 32'hFFFF_FFFF, 1, 1, 0);
        cycle(1, 4, 0, 16'h0, 32'h0);
        expect_search("R8 miss after clear", 32'hCAFE_F00D, 0, 0, 0);
        // mixed traffic against the model
        for (int t = 0; t < 40; t++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (t % 5)
                0: put_pattern(int'(lfsr[4:0]), lfsr);
                1: cycle(1, 0, 0, 16'h0, lfsr);
                2: cycle(1, 1, 0, 16'h0, (t % 2 == 0) ? 32'h1234_5600 : 32'h5555_AAAA);
                3: put_mask(int'(lfsr[9:5]), {16'h0, lfsr[15:0]});
                default: cycle(1, 0, 0, 16'h0, 32'h1234_5678);
            endcase
        end
        repeat (3) idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule